// File: doc/BRIEF.md
# Gated Auto-Reload Timer/Counter

This block is a 16-bit up-counter that reloads itself when it wraps past its top value. Its increment source is selectable. In timer mode it counts the system clock, either divided by twelve or undivided. In counter mode it counts falling edges on an external pin, which first passes through a synchronizer. Counting is enabled by a run bit. When gate mode is selected, counting also needs an external gate input to be high, so the block can measure the width of a high pulse on that input.

The reload value lives in two hidden byte registers that share the write strobes of the high and low count bytes. The run bit decides where a write goes. While the timer is stopped, a write loads the count byte and the matching reload byte together. While it runs, a write changes only the reload byte, and the new value takes effect at the next wrap.

A wrap raises a sticky overflow flag, which stays set until a clear strobe. The flag drives an interrupt request. In normal mode the request needs both the global enable and the timer enable. In non-maskable mode only the timer enable matters. Once the timer enable has been seen high in that mode, the enable latches on and holds until reset, whatever happens to the enable and mode inputs afterwards.

Top module: `reload_timer`

## Requirements
- R1: With gate_mode=0 the count advances only while run=1. With gate_mode=1 it advances only while run=1 and gate_in=1. A stopped count holds its value.
- R2: With ext_sel=1, each falling edge of cnt_pin adds one to the count on the third rising clock edge after the pin goes low (two synchronizer stages plus the counter register). Rising edges of cnt_pin do not change the count.
- R3: With ext_sel=0 and rate_fast=1, the count rises by one on every clock while enabled. With rate_fast=0 the first increment lands on the 12th rising edge after the run condition becomes true, and later increments follow every 12 clocks.
- R4: When the count is 0xFFFF and an increment is due, reload_evt is high in that cycle. On the next edge the count takes the reload value held before that edge.
- R5: With run=0, a write through wr_lo or wr_hi puts wr_data into the low byte (bits 7:0) or the high byte (bits 15:8) of both the count and the reload value on the same edge.
- R6: With run=1, a write through wr_lo or wr_hi changes only the addressed byte of the reload value. The count keeps advancing without disturbance.
- R7: ovf_flag is set by a wrap and holds until flag_clr is pulsed. If a wrap and flag_clr land on the same edge, the wrap wins.
- R8: With nm_mode=0, irq = ovf_flag AND glob_ie AND tmr_ie.
- R9: With nm_mode=1, irq = ovf_flag AND tmr_ie, and glob_ie has no effect.
- R10: After tmr_ie=1 and nm_mode=1 are both seen at a clock edge, irq follows ovf_flag alone until reset, whatever glob_ie, tmr_ie and nm_mode do.
- R11: After reset the count, the reload value, ovf_flag and irq are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Run bit |
| gate_mode | input | 1 | 1: the gate_in input also enables counting |
| gate_in | input | 1 | External gate level, synchronous to clk |
| ext_sel | input | 1 | 0: count the system clock, 1: count cnt_pin falling edges |
| rate_fast | input | 1 | 0: divide by 12, 1: divide by 1 |
| cnt_pin | input | 1 | External count pin, asynchronous |
| wr_lo | input | 1 | Write strobe for the low count/reload byte |
| wr_hi | input | 1 | Write strobe for the high count/reload byte |
| wr_data | input | 8 | Write data byte |
| flag_clr | input | 1 | Clears ovf_flag |
| glob_ie | input | 1 | Global interrupt enable |
| tmr_ie | input | 1 | Timer interrupt enable |
| nm_mode | input | 1 | Non-maskable interrupt mode select |
| count_val | output | 16 | Live count |
| reload_val | output | 16 | Hidden reload value |
| reload_evt | output | 1 | High in the cycle whose edge wraps and reloads |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: a 16-bit count, a divide ratio of 12 and two synchronizer stages. Those values put the twelfth-edge first increment and the three-edge pin latency within easy reach of directed waits. The 0xFFFF wrap is reached cheaply by preloading the count with stopped writes and then retargeting the reload value with writes while the timer runs. That one scenario therefore exercises both paths of the write steering and the wrap in a handful of cycles.

// File: rtl/rt_pkg.sv
package rt_pkg;

  // An increment is due when the prescaler sits on its last state.
  function automatic logic presc_due(input logic [7:0] presc, input int unsigned div);
    return presc == 8'(div - 1);
  endfunction

  // Wrap condition: every bit of the count is set and a step is due.
  function automatic logic wraps(input logic [15:0] cnt, input logic step, input int unsigned w);
    logic [15:0] top;
    top = 16'((32'd1 << w) - 1);
    return step && (cnt == top);
  endfunction

  // Replace one byte lane of a word.
  function automatic logic [15:0] put_byte(input logic [15:0] word, input logic [7:0] b,
                                           input logic hi);
    return hi ? {b, word[7:0]} : {word[15:8], b};
  endfunction

endpackage

// File: rtl/rt_prescale.sv
module rt_prescale #(
  parameter int unsigned DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  output logic tick
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PW-1:0] presc;
  logic          last;

  assign last = rt_pkg::presc_due(8'(presc), DIV);
  assign tick = enable && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           presc <= '0;
    else if (!enable)     presc <= '0;
    else if (last)        presc <= '0;
    else                  presc <= presc + 1'b1;
  end
endmodule

// File: rtl/rt_edge_sync.sv
module rt_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b0;
    else        chain[0] <= pin;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[i] <= 1'b0;
      else        chain[i] <= chain[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= chain[STAGES-1];
  end

  assign fall = prev && !chain[STAGES-1];
endmodule

// File: rtl/rt_count_core.sv
module rt_count_core #(
  parameter int unsigned W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           step,
  input  logic           run,
  input  logic           wr_lo,
  input  logic           wr_hi,
  input  logic [W/2-1:0] wr_data,
  output logic [W-1:0]   count,
  output logic [W-1:0]   reload,
  output logic           wrap
);
  localparam int unsigned HW = W / 2;

  logic [W-1:0] reload_nxt;
  logic [W-1:0] count_nxt;

  assign wrap = rt_pkg::wraps(16'(count), step, W);

  always_comb begin
    reload_nxt = reload;
    if (wr_lo) reload_nxt[HW-1:0] = wr_data;
    if (wr_hi) reload_nxt[W-1:HW] = wr_data;
  end

  always_comb begin
    count_nxt = count;
    if (!run && (wr_lo || wr_hi)) begin
      if (wr_lo) count_nxt[HW-1:0] = wr_data;
      if (wr_hi) count_nxt[W-1:HW] = wr_data;
    end else if (wrap) begin
      count_nxt = reload;
    end else if (step) begin
      count_nxt = count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      reload <= '0;
    end else begin
      count  <= count_nxt;
      reload <= reload_nxt;
    end
  end
endmodule

// File: rtl/rt_irq_ctl.sv
module rt_irq_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap,
  input  logic flag_clr,
  input  logic glob_ie,
  input  logic tmr_ie,
  input  logic nm_mode,
  output logic flag,
  output logic nm_latched,
  output logic irq
);
  logic allow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (wrap)     flag <= 1'b1;
    else if (flag_clr) flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  nm_latched <= 1'b0;
    else if (nm_mode && tmr_ie)  nm_latched <= 1'b1;
  end

  always_comb begin
    if (nm_latched)   allow = 1'b1;
    else if (nm_mode) allow = tmr_ie;
    else              allow = tmr_ie && glob_ie;
  end

  assign irq = flag && allow;
endmodule

// File: rtl/reload_timer.sv
module reload_timer #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned DIV         = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               gate_mode,
  input  logic               gate_in,
  input  logic               ext_sel,
  input  logic               rate_fast,
  input  logic               cnt_pin,
  input  logic               wr_lo,
  input  logic               wr_hi,
  input  logic [CNT_W/2-1:0] wr_data,
  input  logic               flag_clr,
  input  logic               glob_ie,
  input  logic               tmr_ie,
  input  logic               nm_mode,
  output logic [CNT_W-1:0]   count_val,
  output logic [CNT_W-1:0]   reload_val,
  output logic               reload_evt,
  output logic               ovf_flag,
  output logic               irq
);
  // Named internal events, visible to the bound checker.
  logic run_cond;
  logic slow_tick;
  logic pin_fall;
  logic step;
  logic wrap;
  logic nm_latched;

  assign run_cond = run && (!gate_mode || gate_in);

  rt_prescale #(.DIV(DIV)) u_presc (
    .clk(clk), .rst_n(rst_n), .enable(run_cond && !ext_sel && !rate_fast),
    .tick(slow_tick)
  );

  rt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(cnt_pin), .fall(pin_fall)
  );

  always_comb begin
    if (!run_cond)      step = 1'b0;
    else if (ext_sel)   step = pin_fall;
    else if (rate_fast) step = 1'b1;
    else                step = slow_tick;
  end

  rt_count_core #(.W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .step(step), .run(run),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
    .count(count_val), .reload(reload_val), .wrap(wrap)
  );

  rt_irq_ctl u_irq (
    .clk(clk), .rst_n(rst_n), .wrap(wrap), .flag_clr(flag_clr),
    .glob_ie(glob_ie), .tmr_ie(tmr_ie), .nm_mode(nm_mode),
    .flag(ovf_flag), .nm_latched(nm_latched), .irq(irq)
  );

  assign reload_evt = wrap;
endmodule

// File: rtl/rt_checker.sv
module rt_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             run_cond,
  input logic             wr_lo,
  input logic             wr_hi,
  input logic [CNT_W/2-1:0] wr_data,
  input logic             step,
  input logic             flag_clr,
  input logic [CNT_W-1:0] count_val,
  input logic [CNT_W-1:0] reload_val,
  input logic             reload_evt,
  input logic             ovf_flag,
  input logic             nm_latched,
  input logic             irq
);
  // R1: no step and no write leaves the count unchanged
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_cond && !wr_lo && !wr_hi) |=> $stable(count_val));

  // R4: a wrap loads the previously held reload value
  a_r4_wrap_reload: assert property (@(posedge clk) disable iff (!rst_n)
    reload_evt |=> (count_val == $past(reload_val)));

  // R5: a stopped low-byte write lands in both registers
  a_r5_stopped_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && wr_lo) |=> (count_val[7:0] == $past(wr_data) && reload_val[7:0] == $past(wr_data)));

  // R6: a running write with no step leaves the count alone
  a_r6_running_write: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (wr_lo || wr_hi) && !step) |=> $stable(count_val));

  // R7: the flag holds until cleared
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !flag_clr) |=> ovf_flag);

  // R7: a wrap always sets the flag
  a_r7_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    reload_evt |=> ovf_flag);

  // R8: no request without a pending flag
  a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ovf_flag);

  // R10: the non-maskable enable never releases
  a_r10_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    nm_latched |=> nm_latched);

  // R10: once latched, the flag alone drives the request
  a_r10_latched_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (nm_latched && ovf_flag) |-> irq);
endmodule

bind reload_timer rt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .run_cond(run_cond),
  .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data), .step(step),
  .flag_clr(flag_clr), .count_val(count_val), .reload_val(reload_val),
  .reload_evt(reload_evt), .ovf_flag(ovf_flag), .nm_latched(nm_latched),
  .irq(irq)
);

// File: tb/tb_reload_timer.sv
module tb_reload_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 0, gate_mode = 0, gate_in = 0, ext_sel = 0, rate_fast = 0;
  logic        cnt_pin = 1'b1, wr_lo = 0, wr_hi = 0, flag_clr = 0;
  logic        glob_ie = 0, tmr_ie = 0, nm_mode = 0;
  logic [7:0]  wr_data = 8'h00;
  logic [15:0] count_val, reload_val;
  logic        reload_evt, ovf_flag, irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  reload_timer dut (
    .clk(clk), .rst_n(rst_n), .run(run), .gate_mode(gate_mode), .gate_in(gate_in),
    .ext_sel(ext_sel), .rate_fast(rate_fast), .cnt_pin(cnt_pin),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data), .flag_clr(flag_clr),
    .glob_ie(glob_ie), .tmr_ie(tmr_ie), .nm_mode(nm_mode),
    .count_val(count_val), .reload_val(reload_val), .reload_evt(reload_evt),
    .ovf_flag(ovf_flag), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Stopped write of a full 16-bit value, low byte then high byte.
  task automatic load16(input logic [15:0] v);
    wr_lo = 1; wr_data = v[7:0]; cyc(1);
    wr_lo = 0; wr_hi = 1; wr_data = v[15:8]; cyc(1);
    wr_hi = 0;
  endtask

  task automatic t_reset;
    check("R11 count", 32'(count_val), 32'h0);
    check("R11 reload", 32'(reload_val), 32'h0);
    check("R11 flag", 32'(ovf_flag), 32'h0);
    check("R11 irq", 32'(irq), 32'h0);
  endtask

  task automatic t_stopped_write;
    wr_lo = 1; wr_data = 8'h34; cyc(1); wr_lo = 0;
    check("R5 lo count", 32'(count_val), 32'h0034);
    check("R5 lo reload", 32'(reload_val), 32'h0034);
    wr_hi = 1; wr_data = 8'h12; cyc(1); wr_hi = 0;
    check("R5 hi count", 32'(count_val), 32'h1234);
    check("R5 hi reload", 32'(reload_val), 32'h1234);
  endtask

  task automatic t_fast;
    rate_fast = 1; run = 1; cyc(5); run = 0;
    check("R3 fast count", 32'(count_val), 32'h1239);
    cyc(3);
    check("R1 stopped hold", 32'(count_val), 32'h1239);
  endtask

  task automatic t_slow;
    load16(16'h0000);
    rate_fast = 0; run = 1; cyc(11);
    check("R3 slow before 12th", 32'(count_val), 32'h0);
    cyc(1);
    check("R3 slow at 12th", 32'(count_val), 32'h1);
    cyc(12);
    check("R3 slow second", 32'(count_val), 32'h2);
    run = 0; cyc(1);
  endtask

  task automatic t_gate;
    load16(16'h0100);
    rate_fast = 1; gate_mode = 1; gate_in = 0; run = 1; cyc(5);
    check("R1 gate low holds", 32'(count_val), 32'h0100);
    gate_in = 1; cyc(3);
    check("R1 gate high counts", 32'(count_val), 32'h0103);
    gate_in = 0; cyc(2);
    check("R1 gate drop holds", 32'(count_val), 32'h0103);
    run = 0; gate_mode = 0; cyc(1);
  endtask

  task automatic t_run_write;
    load16(16'h0200);
    rate_fast = 1; run = 1; wr_lo = 1; wr_data = 8'h55; cyc(1);
    wr_lo = 0; run = 0;
    check("R6 count undisturbed", 32'(count_val), 32'h0201);
    check("R6 reload lo only", 32'(reload_val), 32'h0255);
    cyc(1);
  endtask

  task automatic t_wrap;
    load16(16'hFFFD);
    rate_fast = 1; run = 1; wr_hi = 1; wr_data = 8'h40; cyc(1);
    wr_hi = 0; wr_lo = 1; wr_data = 8'h00; cyc(1);
    wr_lo = 0;
    check("R4 pre-wrap count", 32'(count_val), 32'hFFFF);
    check("R6 running reload", 32'(reload_val), 32'h4000);
    check("R4 reload_evt high", 32'(reload_evt), 32'h1);
    check("R7 flag not yet", 32'(ovf_flag), 32'h0);
    cyc(1); run = 0;
    check("R4 wrapped count", 32'(count_val), 32'h4000);
    check("R7 flag set", 32'(ovf_flag), 32'h1);
    cyc(3);
    check("R7 flag sticky", 32'(ovf_flag), 32'h1);
  endtask

  task automatic t_irq_normal;
    tmr_ie = 1; glob_ie = 0; nm_mode = 0; cyc(1);
    check("R8 no global", 32'(irq), 32'h0);
    glob_ie = 1; cyc(1);
    check("R8 both enables", 32'(irq), 32'h1);
    tmr_ie = 0; cyc(1);
    check("R8 timer enable off", 32'(irq), 32'h0);
    flag_clr = 1; cyc(1); flag_clr = 0;
    check("R7 flag cleared", 32'(ovf_flag), 32'h0);
    glob_ie = 0;
  endtask

  task automatic t_ext;
    load16(16'h0000);
    ext_sel = 1; run = 1; cyc(2);
    cnt_pin = 0; cyc(2);
    check("R2 two edges after fall", 32'(count_val), 32'h0);
    cyc(1);
    check("R2 third edge", 32'(count_val), 32'h1);
    cnt_pin = 1; cyc(5);
    check("R2 rising ignored", 32'(count_val), 32'h1);
    run = 0; ext_sel = 0; cyc(1);
  endtask

  task automatic t_nmi;
    load16(16'hFFFF);
    rate_fast = 1; run = 1; cyc(1); run = 0;
    check("R4 wrap from all ones", 32'(ovf_flag), 32'h1);
    glob_ie = 0; tmr_ie = 1; nm_mode = 1; cyc(1);
    check("R9 ignores global", 32'(irq), 32'h1);
    tmr_ie = 0; nm_mode = 0; glob_ie = 0; cyc(2);
    check("R10 latched irq", 32'(irq), 32'h1);
    flag_clr = 1; cyc(1); flag_clr = 0;
    check("R10 irq follows flag", 32'(irq), 32'h0);
  endtask

  initial begin
    cyc(2); rst_n = 1; cyc(1);
    t_reset();
    t_stopped_write();
    t_fast();
    t_slow();
    t_gate();
    t_run_write();
    t_wrap();
    t_irq_normal();
    t_ext();
    t_nmi();
    done = 1;
  end

  initial begin
    for (int i = 0; i < 5000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule